// File: doc/BRIEF.md
# SMI Feature Handshake and APM Command Dispatcher

This block is the system-management-interrupt corner of a power-management controller. Firmware first stores a 64-bit request of optional SMI features. It then strobes a confirm write. The block checks the request once against a fixed set of features the host supports and against the dependencies between feature bits. If the request is accepted, the block locks it in as the negotiated set, and no later confirm can change that set until reset.

Writes to the APM command port are then decoded. Two reserved command codes only switch the ACPI mode on or off, with a one-cycle strobe for each. Every other command raises an SMI, but only when the APM enable bit of the SMI enable register is set. If broadcast was negotiated, the SMI pulses on every CPU line. Otherwise it pulses only on the line of the CPU that issued the command.

A power-management config word carries a sticky lock bit. Once the lock bit is set, it cannot be cleared, and bit 0 of the SMI enable register can no longer be written.

Top module: `smi_negotiator`

## Requirements
- R1: After reset, the ok flag, the negotiated set, the SMI lines, the ACPI mode, the two strobes, the SMI enable register and the config word are all 0. A new reset clears a negotiation that had completed.
- R2: A confirm whose stored request has any bit outside the supported mask (default 0x7) leaves the ok flag at 0 and the negotiated set at 0.
- R3: A confirm whose request has hot-plug (bit 1) or hot-unplug (bit 2) set, while broadcast (bit 0) is clear, leaves the ok flag at 0.
- R4: A confirm whose request has hot-unplug (bit 2) set without hot-plug (bit 1) leaves the ok flag at 0, even when broadcast is set.
- R5: A confirm with a valid request sets the ok flag to 1 and the negotiated set to the request, both visible in the cycle after the confirm write.
- R6: Once the ok flag is 1, later confirm writes have no effect, whatever request is stored: the ok flag stays 1 and the negotiated set is unchanged.
- R7: An APM command of 0xE1 sets the ACPI mode to 1 and pulses the enable strobe for one cycle. An APM command of 0x1E clears the ACPI mode and pulses the disable strobe. Neither of these commands raises an SMI.
- R8: Any other APM command raises no SMI while bit 5 (the APM enable bit) of the SMI enable register is 0.
- R9: With bit 5 set and broadcast negotiated, any other APM command drives every SMI line high for exactly the one cycle after the write.
- R10: With bit 5 set and broadcast not negotiated, any other APM command drives only the SMI line selected by the CPU index, for one cycle.
- R11: Bit 4 of the config word is the SMI lock bit. Once it is written as 1, it stays 1, even when a later write carries 0 in that bit.
- R12: While the lock bit is 1, writes to the SMI enable register leave bit 0 unchanged and update every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Store req_data as the requested feature set |
| req_data | input | 64 | Requested feature bits |
| confirm_wr | input | 1 | Validate the stored request and lock it in if valid |
| apm_wr | input | 1 | APM command write |
| apm_cmd | input | 8 | APM command code |
| apm_cpu | input | CPU_IDX_W | Index of the CPU issuing the command |
| smien_wr | input | 1 | SMI enable register write |
| smien_data | input | 32 | SMI enable write data |
| pmcon_wr | input | 1 | Config word write |
| pmcon_data | input | 16 | Config word write data |
| smi_out | output | NUM_CPU | Per-CPU SMI pulses |
| acpi_en_stb | output | 1 | One-cycle strobe on the ACPI-enable command |
| acpi_dis_stb | output | 1 | One-cycle strobe on the ACPI-disable command |
| acpi_mode | output | 1 | Current ACPI mode |
| feat_ok | output | 1 | Negotiation succeeded |
| feat_neg | output | 64 | Negotiated feature set |
| feat_req | output | 64 | Stored request, read back |
| smien_q | output | 32 | SMI enable register, read back |
| pmcon_q | output | 16 | Config word, read back |

## Verification
On every cycle, the assertions check these properties:
- any accepted set stays within the supported mask and keeps the two dependency rules;
- the ok flag and the negotiated set never change once set;
- the two ACPI codes never produce an SMI;
- a non-broadcast SMI hits exactly one line;
- the lock bit is sticky, and it freezes bit 0 of the SMI enable register.

Only the bench scenarios can show the other behaviours:
- that each particular rejected request leaves the ok flag at 0;
- that a valid request is copied exactly;
- that broadcast drives all lines and lasts a single cycle;
- that the other enable bits stay writable under the lock;
- that reset undoes a completed negotiation.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int FEAT_W       = 64;
    localparam int SMIEN_W      = 32;
    localparam int PMCON_W      = 16;
    localparam int CMD_W        = 8;

    localparam int FB_BCAST     = 0;
    localparam int FB_HOTPLUG   = 1;
    localparam int FB_HOTUNPLUG = 2;

    localparam int SMIEN_APM_BIT  = 5;
    localparam int SMIEN_FRZ_BIT  = 0;
    localparam int PMCON_LOCK_BIT = 4;

    localparam logic [CMD_W-1:0] CMD_ACPI_ON  = 8'hE1;
    localparam logic [CMD_W-1:0] CMD_ACPI_OFF = 8'h1E;

    typedef struct packed {
        logic              ok;
        logic [FEAT_W-1:0] neg;
        logic [FEAT_W-1:0] req;
    } feat_state_t;

    typedef struct packed {
        logic [SMIEN_W-1:0] smien;
        logic [PMCON_W-1:0] pmcon;
    } ctrl_state_t;
endpackage

// File: rtl/smi_feat_neg.sv
module smi_feat_neg
    import smi_pkg::*;
#(
    parameter logic [FEAT_W-1:0] HOST_FEATURES = 64'h7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic [FEAT_W-1:0] req_data,
    input  logic              confirm_wr,
    output logic              ok,
    output logic [FEAT_W-1:0] neg,
    output logic [FEAT_W-1:0] req
);
    feat_state_t st_d, st_q;
    logic bad_unsup, bad_bcast, bad_unplug, hp_any;

    always_comb begin
        st_d       = st_q;
        hp_any     = st_q.req[FB_HOTPLUG] | st_q.req[FB_HOTUNPLUG];
        bad_unsup  = |(st_q.req & ~HOST_FEATURES);
        bad_bcast  = hp_any & ~st_q.req[FB_BCAST];
        bad_unplug = st_q.req[FB_HOTUNPLUG] & ~st_q.req[FB_HOTPLUG];
        if (req_wr) begin
            st_d.req = req_data;
        end
        if (confirm_wr && !st_q.ok && !bad_unsup && !bad_bcast && !bad_unplug) begin
            st_d.ok  = 1'b1;
            st_d.neg = st_q.req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ok  = st_q.ok;
    assign neg = st_q.neg;
    assign req = st_q.req;

    assert_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ok |-> ((st_q.neg & ~HOST_FEATURES) == '0));
    assert_hp_needs_bcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ok && (st_q.neg[FB_HOTPLUG] || st_q.neg[FB_HOTUNPLUG])) |-> st_q.neg[FB_BCAST]);
    assert_unplug_needs_plug_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ok && st_q.neg[FB_HOTUNPLUG]) |-> st_q.neg[FB_HOTPLUG]);
    assert_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ok |=> (st_q.ok && $stable(st_q.neg)));
endmodule

// File: rtl/smi_ctrl_regs.sv
module smi_ctrl_regs
    import smi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smien_wr,
    input  logic [SMIEN_W-1:0] smien_data,
    input  logic               pmcon_wr,
    input  logic [PMCON_W-1:0] pmcon_data,
    output logic [SMIEN_W-1:0] smien,
    output logic [PMCON_W-1:0] pmcon,
    output logic               apm_en
);
    ctrl_state_t st_d, st_q;
    logic        lock;

    assign lock = st_q.pmcon[PMCON_LOCK_BIT];

    always_comb begin
        st_d = st_q;
        if (pmcon_wr) begin
            st_d.pmcon = pmcon_data;
            if (lock) st_d.pmcon[PMCON_LOCK_BIT] = 1'b1;
        end
        if (smien_wr) begin
            st_d.smien = smien_data;
            if (lock) st_d.smien[SMIEN_FRZ_BIT] = st_q.smien[SMIEN_FRZ_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smien  = st_q.smien;
    assign pmcon  = st_q.pmcon;
    assign apm_en = st_q.smien[SMIEN_APM_BIT];

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> st_q.pmcon[PMCON_LOCK_BIT]);
    assert_frozen_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(st_q.smien[SMIEN_FRZ_BIT]));
endmodule

// File: rtl/smi_apm_dispatch.sv
module smi_apm_dispatch
    import smi_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    parameter int CPU_IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 apm_wr,
    input  logic [CMD_W-1:0]     apm_cmd,
    input  logic [CPU_IDX_W-1:0] apm_cpu,
    input  logic                 apm_en,
    input  logic                 bcast,
    output logic [NUM_CPU-1:0]   smi,
    output logic                 en_stb,
    output logic                 dis_stb,
    output logic                 acpi
);
    typedef struct packed {
        logic [NUM_CPU-1:0] smi;
        logic               en_stb;
        logic               dis_stb;
        logic               acpi;
    } disp_state_t;

    disp_state_t st_d, st_q;
    logic [NUM_CPU-1:0] one_hot;

    always_comb begin
        one_hot = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (apm_cpu == CPU_IDX_W'(i)) one_hot[i] = 1'b1;
        end
        st_d         = st_q;
        st_d.smi     = '0;
        st_d.en_stb  = 1'b0;
        st_d.dis_stb = 1'b0;
        if (apm_wr) begin
            if (apm_cmd == CMD_ACPI_ON) begin
                st_d.en_stb = 1'b1;
                st_d.acpi   = 1'b1;
            end else if (apm_cmd == CMD_ACPI_OFF) begin
                st_d.dis_stb = 1'b1;
                st_d.acpi    = 1'b0;
            end else if (apm_en) begin
                st_d.smi = bcast ? '1 : one_hot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smi     = st_q.smi;
    assign en_stb  = st_q.en_stb;
    assign dis_stb = st_q.dis_stb;
    assign acpi    = st_q.acpi;

    assert_acpi_no_smi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && (apm_cmd == CMD_ACPI_ON || apm_cmd == CMD_ACPI_OFF)) |=> (st_q.smi == '0));
    assert_strobes_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.en_stb, st_q.dis_stb}));
    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !apm_en |=> (st_q.smi == '0));
    assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && !bcast) |=> ($countones(st_q.smi) <= 1));
    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !apm_wr |=> (st_q.smi == '0));
endmodule

// File: rtl/smi_negotiator.sv
module smi_negotiator
    import smi_pkg::*;
#(
    parameter int                NUM_CPU       = 4,
    parameter int                CPU_IDX_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    parameter logic [FEAT_W-1:0] HOST_FEATURES = 64'h7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_wr,
    input  logic [63:0]          req_data,
    input  logic                 confirm_wr,
    input  logic                 apm_wr,
    input  logic [7:0]           apm_cmd,
    input  logic [CPU_IDX_W-1:0] apm_cpu,
    input  logic                 smien_wr,
    input  logic [31:0]          smien_data,
    input  logic                 pmcon_wr,
    input  logic [15:0]          pmcon_data,
    output logic [NUM_CPU-1:0]   smi_out,
    output logic                 acpi_en_stb,
    output logic                 acpi_dis_stb,
    output logic                 acpi_mode,
    output logic                 feat_ok,
    output logic [63:0]          feat_neg,
    output logic [63:0]          feat_req,
    output logic [31:0]          smien_q,
    output logic [15:0]          pmcon_q
);
    logic apm_en;

    smi_feat_neg #(.HOST_FEATURES(HOST_FEATURES)) u_feat (
        .clk(clk), .rst_n(rst_n),
        .req_wr(req_wr), .req_data(req_data), .confirm_wr(confirm_wr),
        .ok(feat_ok), .neg(feat_neg), .req(feat_req)
    );

    smi_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .smien_wr(smien_wr), .smien_data(smien_data),
        .pmcon_wr(pmcon_wr), .pmcon_data(pmcon_data),
        .smien(smien_q), .pmcon(pmcon_q), .apm_en(apm_en)
    );

    smi_apm_dispatch #(.NUM_CPU(NUM_CPU), .CPU_IDX_W(CPU_IDX_W)) u_disp (
        .clk(clk), .rst_n(rst_n),
        .apm_wr(apm_wr), .apm_cmd(apm_cmd), .apm_cpu(apm_cpu),
        .apm_en(apm_en), .bcast(feat_neg[FB_BCAST]),
        .smi(smi_out), .en_stb(acpi_en_stb), .dis_stb(acpi_dis_stb), .acpi(acpi_mode)
    );
endmodule

// File: tb/smi_negotiator_tb.sv
module smi_negotiator_tb;
    localparam int NCPU = 4;
    localparam int IW   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_wr = 1'b0, confirm_wr = 1'b0, apm_wr = 1'b0;
    logic            smien_wr = 1'b0, pmcon_wr = 1'b0;
    logic [63:0]     req_data = '0;
    logic [7:0]      apm_cmd = '0;
    logic [IW-1:0]   apm_cpu = '0;
    logic [31:0]     smien_data = '0;
    logic [15:0]     pmcon_data = '0;
    logic [NCPU-1:0] smi_out;
    logic            acpi_en_stb, acpi_dis_stb, acpi_mode, feat_ok;
    logic [63:0]     feat_neg, feat_req;
    logic [31:0]     smien_q;
    logic [15:0]     pmcon_q;

    smi_negotiator #(.NUM_CPU(NCPU), .CPU_IDX_W(IW)) u_dut (.*);

    always #4 clk = ~clk;

    typedef enum int {S_OK, S_NEG, S_SMI, S_ACPI, S_EN, S_DIS, S_SMIEN, S_PMCON} sig_t;
    typedef struct {
        int          due;
        sig_t        sig;
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] probe(sig_t s);
        case (s)
            S_OK:    return 64'(feat_ok);
            S_NEG:   return feat_neg;
            S_SMI:   return 64'(smi_out);
            S_ACPI:  return 64'(acpi_mode);
            S_EN:    return 64'(acpi_en_stb);
            S_DIS:   return 64'(acpi_dis_stb);
            S_SMIEN: return 64'(smien_q);
            default: return 64'(pmcon_q);
        endcase
    endfunction

    // monitor: pops items that are due and compares
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [63:0] act;
            it  = q.pop_front();
            act = probe(it.sig);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s %s: actual 0x%0h expected 0x%0h", it.req, it.sig.name(), act, it.exp);
            end
        end
    end

    task automatic expect_next(sig_t s, logic [63:0] v, string r);
        item_t it;
        it.due = cyc + 1; it.sig = s; it.exp = v; it.req = r;
        q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        req_wr = 0; confirm_wr = 0; apm_wr = 0; smien_wr = 0; pmcon_wr = 0;
    endtask

    task automatic do_req(logic [63:0] d);
        req_wr = 1; req_data = d; step();
    endtask
    task automatic do_confirm();
        confirm_wr = 1; step();
    endtask
    task automatic do_apm(logic [7:0] c, logic [IW-1:0] cpu);
        apm_wr = 1; apm_cmd = c; apm_cpu = cpu; step();
    endtask
    task automatic do_smien(logic [31:0] d);
        smien_wr = 1; smien_data = d; step();
    endtask
    task automatic do_pmcon(logic [15:0] d);
        pmcon_wr = 1; pmcon_data = d; step();
    endtask

    task automatic expect_reset();
        expect_next(S_OK, 0, "R1"); expect_next(S_NEG, 0, "R1");
        expect_next(S_SMI, 0, "R1"); expect_next(S_ACPI, 0, "R1");
        expect_next(S_EN, 0, "R1"); expect_next(S_DIS, 0, "R1");
        expect_next(S_SMIEN, 0, "R1"); expect_next(S_PMCON, 0, "R1");
    endtask

    initial begin
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        expect_reset(); step();

        // R8: enable bit clear, ordinary command
        expect_next(S_SMI, 0, "R8"); do_apm(8'h42, 2'd1);

        // R2: unsupported bit 3
        do_req(64'h8);
        expect_next(S_OK, 0, "R2"); expect_next(S_NEG, 0, "R2"); do_confirm();
        // R3: hot-plug without broadcast, hot-unplug without broadcast
        do_req(64'h2);
        expect_next(S_OK, 0, "R3"); do_confirm();
        do_req(64'h6);
        expect_next(S_OK, 0, "R3"); do_confirm();
        // R4: broadcast + unplug without plug
        do_req(64'h5);
        expect_next(S_OK, 0, "R4"); expect_next(S_NEG, 0, "R4"); do_confirm();

        // R10: no broadcast negotiated, single target
        expect_next(S_SMIEN, 64'h20, "R10"); do_smien(32'h20);
        expect_next(S_SMI, 64'h4, "R10"); do_apm(8'h42, 2'd2);
        expect_next(S_SMI, 64'h8, "R10"); do_apm(8'h00, 2'd3);

        // R5: valid request
        do_req(64'h3);
        expect_next(S_OK, 1, "R5"); expect_next(S_NEG, 64'h3, "R5"); do_confirm();
        // R6: later confirms ignored
        do_req(64'h1);
        expect_next(S_OK, 1, "R6"); expect_next(S_NEG, 64'h3, "R6"); do_confirm();
        do_req(64'h80);
        expect_next(S_NEG, 64'h3, "R6"); do_confirm();

        // R9: broadcast, single cycle
        expect_next(S_SMI, 64'hF, "R9"); do_apm(8'h42, 2'd1);
        expect_next(S_SMI, 0, "R9"); step();

        // R7: ACPI codes
        expect_next(S_EN, 1, "R7"); expect_next(S_DIS, 0, "R7");
        expect_next(S_SMI, 0, "R7"); expect_next(S_ACPI, 1, "R7");
        do_apm(8'hE1, 2'd0);
        expect_next(S_EN, 0, "R7"); expect_next(S_ACPI, 1, "R7"); step();
        expect_next(S_DIS, 1, "R7"); expect_next(S_EN, 0, "R7");
        expect_next(S_SMI, 0, "R7"); expect_next(S_ACPI, 0, "R7");
        do_apm(8'h1E, 2'd2);

        // R11 / R12: lock
        expect_next(S_SMIEN, 64'h21, "R12"); do_smien(32'h21);
        expect_next(S_PMCON, 64'h10, "R11"); do_pmcon(16'h10);
        expect_next(S_SMIEN, 64'h1, "R12"); do_smien(32'h0);
        expect_next(S_SMIEN, 64'h301, "R12"); do_smien(32'h300);
        expect_next(S_PMCON, 64'h10, "R11"); do_pmcon(16'h0);
        expect_next(S_PMCON, 64'h13, "R11"); do_pmcon(16'h3);
        // R8 again: bit 5 now clear
        expect_next(S_SMI, 0, "R8"); do_apm(8'h42, 2'd0);

        // R1: reset clears completed negotiation
        rst_n = 0; step(); step();
        rst_n = 1;
        expect_reset(); step();
        step();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule